// File: doc/BRIEF.md
# SMBus Packet Byte Counter with ACK Policy

This block keeps count of the data bytes that remain in an SMBus packet and decides, for every byte on the bus, whether an ACK or a NACK goes back. The surrounding controller loads a packet size while the bus is idle. It then reports each finished byte with a one-cycle strobe and a flag that says whether the byte carried data or an address. Only data bytes count down. The count never wraps below zero, and a size of zero stands for a quick-command transfer that has no data bytes.

An end-of-packet status flag can be raised after the last data byte or after the PEC byte that follows the data. It stays set until software clears it. The ACK decision for the byte in progress is combinational. It depends on the ACK mode, the role (host or client), the remaining count, whether the PEC byte has already passed, the CRC check result and a software ACK bit. A separate output gives the effective acknowledge seen from the peer, and a host can be set to treat every NACK it receives as an ACK. When a client receives with extended packets enabled, it may reload the count once end-of-packet is set, so that reception runs on into the next block.

Address matching, CRC computation and bus timing live elsewhere.

Top module: `pktack`

## Requirements
- R1: After reset the remaining count is 1 and the end-of-packet flag is 0.
- R2: A size write loads the remaining count one cycle later only while busIdle is 1. Apart from the case in R12, a size write while the bus is busy leaves the count unchanged.
- R3: A byteDone strobe with dataByte=1 lowers a nonzero count by one. With dataByte=0 (address byte) the count is unchanged, and a count of 0 stays at 0.
- R4: With eopMode=2'b01 the flag sets in the cycle after byteDone for a data byte taken at count 1. With eopMode=2'b00 or 2'b11 it never sets.
- R5: With eopMode=2'b10 the flag sets after the PEC byte. The PEC byte is the first data byte finished while the count is 0 and no PEC byte has been taken since the last load.
- R6: The flag is sticky and clears one cycle after eopClr=1. If a set and a clear happen in the same cycle, the set wins.
- R7: ackOut (1 = ACK, 0 = NACK) equals swAck when ackMode=2'b00.
- R8: ackOut is 1 for every byte when ackMode=2'b01.
- R9: With ackMode=2'b10, ackOut is 0 for a data byte at count 1 and 1 for any other byte.
- R10: With ackMode=2'b11, the PEC byte (as defined in R5) gets ackOut=0 when isHost=1 and ackOut=crcOk when isHost=0. Every other byte gets ackOut=1.
- R11: peerAck is 1 when rxNack=0, or when rxNack=1 with isHost=1 and nackIgnore=1. Otherwise it is 0.
- R12: With isHost=0, extEn=1 and the end-of-packet flag set, a size write loads the count even while the bus is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busIdle | input | 1 | Bus is idle, so the size may be loaded |
| sizeWr | input | 1 | Strobe that loads sizeIn |
| sizeIn | input | 16 | Packet size in data bytes, address bytes excluded |
| dataByte | input | 1 | Current byte is a data byte (1) or an address byte (0) |
| byteDone | input | 1 | One-cycle strobe at the end of a byte |
| eopMode | input | 2 | End-of-packet status mode |
| ackMode | input | 2 | ACK policy mode |
| isHost | input | 1 | Role: 1 host, 0 client |
| nackIgnore | input | 1 | Host treats a received NACK as ACK |
| swAck | input | 1 | Software ACK bit used in ackMode 00 |
| crcOk | input | 1 | CRC residue is zero |
| extEn | input | 1 | Extended packet reload enable (client receive) |
| eopClr | input | 1 | Clears the end-of-packet flag |
| rxNack | input | 1 | NACK received from the peer |
| remaining | output | 16 | Data bytes still to come |
| eopFlag | output | 1 | Sticky end-of-packet status |
| ackOut | output | 1 | ACK decision for the current byte |
| peerAck | output | 1 | Effective acknowledge from the peer |

## Verification
The count is driven with mixed address and data strobes, and with sizes of 1, 2 and 3. This separates counting every byte from counting data bytes only, and shows the floor at zero. Each end-of-packet mode runs with the same byte sequence, so a flag raised one byte early or late, or raised in a disabled mode, shows up. A set and a clear are also applied together. The four ACK modes are held on bytes at count 2, at count 1, at the PEC position and after the PEC byte, with both roles and both CRC results. This pins down which position draws the NACK. The reload window is tried with and without extended mode, and with each role, while the bus is busy.

// File: rtl/pktack_pkg.sv
package pktack_pkg;
  typedef struct packed {
    logic load;
    logic dec;
    logic pecTake;
    logic eopSet;
  } ctlStrb_t;

  localparam logic [1:0] EOP_OFF  = 2'b00;
  localparam logic [1:0] EOP_DATA = 2'b01;
  localparam logic [1:0] EOP_PEC  = 2'b10;

  localparam logic [1:0] ACK_SW   = 2'b00;
  localparam logic [1:0] ACK_ALL  = 2'b01;
  localparam logic [1:0] ACK_LAST = 2'b10;
  localparam logic [1:0] ACK_CRC  = 2'b11;
endpackage

// File: rtl/pktack_ctl.sv
module pktack_ctl
  import pktack_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busIdle,
  input  logic          sizeWr,
  input  logic          dataByte,
  input  logic          byteDone,
  input  logic [1:0]    eopMode,
  input  logic [1:0]    ackMode,
  input  logic          isHost,
  input  logic          swAck,
  input  logic          crcOk,
  input  logic          extEn,
  input  logic [CW-1:0] cnt,
  input  logic          pecSeen,
  input  logic          eopFlag,
  output ctlStrb_t      strb,
  output logic          ackOut
);
  logic lastData;
  logic pecByte;
  logic loadOk;

  always_comb begin
    lastData = dataByte && (cnt == CW'(1));
    pecByte  = dataByte && (cnt == '0) && !pecSeen;
    loadOk   = busIdle || (extEn && !isHost && eopFlag);

    strb.load    = sizeWr && loadOk;
    strb.dec     = byteDone && dataByte && (cnt != '0);
    strb.pecTake = byteDone && pecByte;
    strb.eopSet  = byteDone && (((eopMode == EOP_DATA) && lastData) ||
                                ((eopMode == EOP_PEC) && pecByte));
  end

  always_comb begin
    unique case (ackMode)
      ACK_SW:   ackOut = swAck;
      ACK_ALL:  ackOut = 1'b1;
      ACK_LAST: ackOut = !lastData;
      default:  ackOut = pecByte ? (!isHost && crcOk) : 1'b1;
    endcase
  end

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && !dataByte && !sizeWr) |=> (cnt == $past(cnt)));

  // R2
  busy_noload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sizeWr && !busIdle && !eopFlag && !byteDone) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/pktack_dp.sv
module pktack_dp
  import pktack_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrb_t      strb,
  input  logic [CW-1:0] sizeIn,
  input  logic          eopClr,
  output logic [CW-1:0] cnt,
  output logic          pecSeen,
  output logic          eopFlag
);
  localparam logic [CW-1:0] CNT_RST = CW'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= CNT_RST;
      pecSeen <= 1'b0;
      eopFlag <= 1'b0;
    end else begin
      if (strb.load)      cnt <= sizeIn;
      else if (strb.dec)  cnt <= cnt - CW'(1);

      if (strb.load)         pecSeen <= 1'b0;
      else if (strb.pecTake) pecSeen <= 1'b1;

      if (strb.eopSet)    eopFlag <= 1'b1;
      else if (eopClr)    eopFlag <= 1'b0;
    end
  end

  // R3
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0 && !strb.load) |=> (cnt == '0));

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dec && !strb.load) |=> (cnt == $past(cnt) - CW'(1)));

  // R6
  eop_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eopFlag && !eopClr) |=> eopFlag);
endmodule

// File: rtl/pktack.sv
module pktack
  import pktack_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busIdle,
  input  logic          sizeWr,
  input  logic [CW-1:0] sizeIn,
  input  logic          dataByte,
  input  logic          byteDone,
  input  logic [1:0]    eopMode,
  input  logic [1:0]    ackMode,
  input  logic          isHost,
  input  logic          nackIgnore,
  input  logic          swAck,
  input  logic          crcOk,
  input  logic          extEn,
  input  logic          eopClr,
  input  logic          rxNack,
  output logic [CW-1:0] remaining,
  output logic          eopFlag,
  output logic          ackOut,
  output logic          peerAck
);
  ctlStrb_t      strb;
  logic [CW-1:0] cnt;
  logic          pecSeen;

  pktack_ctl #(.CW(CW)) i_ctl (
    .clk(clk), .rstN(rstN), .busIdle(busIdle), .sizeWr(sizeWr),
    .dataByte(dataByte), .byteDone(byteDone), .eopMode(eopMode),
    .ackMode(ackMode), .isHost(isHost), .swAck(swAck), .crcOk(crcOk),
    .extEn(extEn), .cnt(cnt), .pecSeen(pecSeen), .eopFlag(eopFlag),
    .strb(strb), .ackOut(ackOut)
  );

  pktack_dp #(.CW(CW)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sizeIn(sizeIn), .eopClr(eopClr),
    .cnt(cnt), .pecSeen(pecSeen), .eopFlag(eopFlag)
  );

  assign remaining = cnt;
  assign peerAck   = !rxNack || (isHost && nackIgnore);

  // R11
  client_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxNack && !isHost) |-> !peerAck);
endmodule

// File: tb/test_pktack.sv
module test_pktack;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busIdle = 1'b1, sizeWr = 1'b0, dataByte = 1'b0, byteDone = 1'b0;
  logic [15:0] sizeIn = '0;
  logic [1:0]  eopMode = 2'b00, ackMode = 2'b00;
  logic        isHost = 1'b1, nackIgnore = 1'b0, swAck = 1'b0, crcOk = 1'b0;
  logic        extEn = 1'b0, eopClr = 1'b0, rxNack = 1'b0;
  logic [15:0] remaining;
  logic        eopFlag, ackOut, peerAck;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pktack i_pktack (
    .clk(clk), .rstN(rstN), .busIdle(busIdle), .sizeWr(sizeWr), .sizeIn(sizeIn),
    .dataByte(dataByte), .byteDone(byteDone), .eopMode(eopMode), .ackMode(ackMode),
    .isHost(isHost), .nackIgnore(nackIgnore), .swAck(swAck), .crcOk(crcOk),
    .extEn(extEn), .eopClr(eopClr), .rxNack(rxNack), .remaining(remaining),
    .eopFlag(eopFlag), .ackOut(ackOut), .peerAck(peerAck)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doLoad(input logic [15:0] v);
    @(negedge clk); sizeIn = v; sizeWr = 1'b1;
    @(negedge clk); sizeWr = 1'b0;
  endtask

  task automatic pulseByte(input logic isData, input logic clr);
    @(negedge clk); dataByte = isData; byteDone = 1'b1; eopClr = clr;
    @(negedge clk); byteDone = 1'b0; eopClr = 1'b0;
  endtask

  task automatic clearEop();
    @(negedge clk); eopClr = 1'b1;
    @(negedge clk); eopClr = 1'b0;
  endtask

  task automatic tReset();
    chk("R1 remaining", int'(remaining), 1);
    chk("R1 eop", int'(eopFlag), 0);
  endtask

  task automatic tLoad();
    busIdle = 1'b0;
    doLoad(16'd5);
    chk("R2 busy load ignored", int'(remaining), 1);
    busIdle = 1'b1;
    doLoad(16'd3);
    chk("R2 idle load", int'(remaining), 3);
  endtask

  task automatic tCount();
    pulseByte(1'b0, 1'b0);
    chk("R3 address byte holds", int'(remaining), 3);
    pulseByte(1'b1, 1'b0);
    chk("R3 data byte decrements", int'(remaining), 2);
    doLoad(16'd1);
    pulseByte(1'b1, 1'b0);
    chk("R3 reach zero", int'(remaining), 0);
    pulseByte(1'b1, 1'b0);
    chk("R3 no wrap", int'(remaining), 0);
  endtask

  task automatic tEopData();
    eopMode = 2'b01;
    doLoad(16'd2);
    pulseByte(1'b1, 1'b0);
    chk("R4 not after first byte", int'(eopFlag), 0);
    pulseByte(1'b1, 1'b0);
    chk("R4 set after last data", int'(eopFlag), 1);
    pulseByte(1'b0, 1'b0);
    chk("R6 sticky", int'(eopFlag), 1);
    clearEop();
    chk("R6 cleared", int'(eopFlag), 0);
    for (int m = 0; m < 2; m++) begin
      eopMode = (m == 0) ? 2'b00 : 2'b11;
      doLoad(16'd2);
      pulseByte(1'b1, 1'b0);
      pulseByte(1'b1, 1'b0);
      pulseByte(1'b1, 1'b0);
      chk("R4 disabled mode never sets", int'(eopFlag), 0);
    end
  endtask

  task automatic tEopPec();
    eopMode = 2'b10;
    doLoad(16'd1);
    pulseByte(1'b1, 1'b0);
    chk("R5 not after data", int'(eopFlag), 0);
    pulseByte(1'b1, 1'b0);
    chk("R5 set after PEC", int'(eopFlag), 1);
    clearEop();
    eopMode = 2'b01;
    doLoad(16'd1);
    pulseByte(1'b1, 1'b1);
    chk("R6 set wins over clear", int'(eopFlag), 1);
    clearEop();
  endtask

  task automatic tAck();
    eopMode = 2'b00;
    ackMode = 2'b00;
    @(negedge clk); swAck = 1'b0; #1;
    chk("R7 swAck 0", int'(ackOut), 0);
    swAck = 1'b1; #1;
    chk("R7 swAck 1", int'(ackOut), 1);
    ackMode = 2'b01;
    doLoad(16'd1);
    dataByte = 1'b1; #1;
    chk("R8 ack last byte", int'(ackOut), 1);
    ackMode = 2'b10; #1;
    chk("R9 nack final byte", int'(ackOut), 0);
    dataByte = 1'b0; #1;
    chk("R9 address byte acked", int'(ackOut), 1);
    doLoad(16'd2);
    dataByte = 1'b1; #1;
    chk("R9 ack earlier byte", int'(ackOut), 1);
    ackMode = 2'b11;
    isHost = 1'b1;
    doLoad(16'd1);
    dataByte = 1'b1; #1;
    chk("R10 host data acked", int'(ackOut), 1);
    pulseByte(1'b1, 1'b0);
    dataByte = 1'b1; #1;
    chk("R10 host nack PEC", int'(ackOut), 0);
    isHost = 1'b0; crcOk = 1'b1; #1;
    chk("R10 client crc ok", int'(ackOut), 1);
    crcOk = 1'b0; #1;
    chk("R10 client crc bad", int'(ackOut), 0);
    pulseByte(1'b1, 1'b0);
    dataByte = 1'b1; #1;
    chk("R10 after PEC acked", int'(ackOut), 1);
    isHost = 1'b1;
  endtask

  task automatic tPeer();
    @(negedge clk);
    rxNack = 1'b1; isHost = 1'b1; nackIgnore = 1'b1; #1;
    chk("R11 host ignore", int'(peerAck), 1);
    isHost = 1'b0; #1;
    chk("R11 client no ignore", int'(peerAck), 0);
    isHost = 1'b1; nackIgnore = 1'b0; #1;
    chk("R11 host normal nack", int'(peerAck), 0);
    rxNack = 1'b0; #1;
    chk("R11 ack", int'(peerAck), 1);
  endtask

  task automatic tExt();
    ackMode = 2'b01; eopMode = 2'b01; isHost = 1'b0; extEn = 1'b1;
    doLoad(16'd1);
    busIdle = 1'b0;
    pulseByte(1'b1, 1'b0);
    chk("R12 eop up", int'(eopFlag), 1);
    doLoad(16'd4);
    chk("R12 reload after eop", int'(remaining), 4);
    extEn = 1'b0;
    doLoad(16'd7);
    chk("R12 no reload without ext", int'(remaining), 4);
    extEn = 1'b1; isHost = 1'b1;
    doLoad(16'd7);
    chk("R12 no reload as host", int'(remaining), 4);
    clearEop();
    isHost = 1'b0;
    doLoad(16'd9);
    chk("R2 no reload without eop", int'(remaining), 4);
    busIdle = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tLoad();
    tCount();
    tEopData();
    tEopPec();
    tAck();
    tPeer();
    tExt();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule